// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block makes the hazard decisions for a five-stage in-order pipeline with fetch, decode, execute, memory and writeback stages. Each cycle it reads the register indices, write-enable flags and load flag held in the stage registers, plus the branch outcome resolved in execute. It returns an operand-forwarding select for each of the two execute-stage source operands, a hold for the fetch and decode stages, a bubble request into execute, and squash requests for the fetch and decode slots.

The forwarding selects are combinational, so the datapath muxes are steered in the same cycle that the indices arrive. The only state is a one-bit record of the previous cycle's load-use stall, which limits a stall to one cycle, and a two-flop reset synchronizer. The register file writes before it is read within a cycle. A producer three instructions ahead of a consumer therefore needs no bypass, and only the memory and writeback stages are forwarding sources.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: When the memory-stage write-enable is high and its destination index is nonzero and equals an execute-stage source index, that source's select is 2'b10 (memory-stage value).
- R2: When only the writeback stage has write-enable high with a nonzero destination equal to an execute-stage source index, that source's select is 2'b01 (writeback-stage value).
- R3: When both the memory and writeback stages qualify for the same source, the select is 2'b10, so the younger producer wins.
- R4: A destination index of zero never causes forwarding and never causes a load-use stall.
- R5: A stage whose write-enable is low is never used as a forwarding source, even when its destination index matches.
- R6: When execute holds a load with write-enable high and a nonzero destination that equals either decode source index, stall_fd and bubble_ex are high in that same cycle. Two cycles later, the dependent instruction in execute receives the loaded value through select 2'b01.
- R7: A load-use stall lasts exactly one cycle. In the cycle after a stall, stall_fd is low even if the stage contents still show the hazard.
- R8: A non-load producer in execute whose destination matches a decode source causes no stall. The next cycle, the value is forwarded from the memory stage.
- R9: When a branch is valid in execute and mispredicted, flush_if and flush_id are both high. A correctly predicted branch, or no valid branch, flushes nothing.
- R10: In a cycle with both a mispredict and a load-use hazard, the flush wins: stall_fd and bubble_ex are low.
- R11: A source with no qualifying match in the memory or writeback stage selects 2'b00 (register-file value).
- R12: stall_fd is low while rst_n is low and at the first rising clock edge after rst_n is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| id_rs1 | input | AW | First source index of the decode-stage instruction |
| id_rs2 | input | AW | Second source index of the decode-stage instruction |
| ex_rs1 | input | AW | First source index of the execute-stage instruction |
| ex_rs2 | input | AW | Second source index of the execute-stage instruction |
| ex_rd | input | AW | Destination index of the execute-stage instruction |
| ex_we | input | 1 | Execute-stage instruction writes a register |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | AW | Destination index in the memory stage |
| mem_we | input | 1 | Memory-stage write-enable |
| wb_rd | input | AW | Destination index in the writeback stage |
| wb_we | input | 1 | Writeback-stage write-enable |
| br_valid | input | 1 | A branch is resolving in execute this cycle |
| br_mispredict | input | 1 | The resolving branch was mispredicted |
| fwd_a | output | 2 | Select for the first execute operand: 00 register file, 01 writeback, 10 memory |
| fwd_b | output | 2 | Select for the second execute operand, same encoding |
| stall_fd | output | 1 | Hold the fetch and decode stage registers |
| bubble_ex | output | 1 | Insert a bubble into execute |
| flush_if | output | 1 | Squash the instruction in fetch |
| flush_id | output | 1 | Squash the instruction in decode |

## Verification
Directed patterns place a matching producer in the memory stage only, in the writeback stage only, in both, and in neither. These cases separate the priority order from the no-match default. Further patterns use index zero and a matching stage with its write-enable low, to show that each qualifier is really applied. The load-use sequence holds the hazard for consecutive cycles and then follows the load into writeback, which separates the one-cycle limit from a persistent stall. A mispredict coinciding with a load-use hazard shows which decision wins. A long run of stage contents drawn from a four-index range then produces dense collisions, and every cycle is compared with a behavioural model.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hzd_fwd_mux.sv
module hzd_fwd_mux
  import hzd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_we,
  output fwd_sel_e      sel
);
  logic src_nz;
  logic mem_hit;
  logic wb_hit;

  always_comb begin
    src_nz  = (src != '0);
    mem_hit = src_nz && mem_we && (mem_rd == src);
    wb_hit  = src_nz && wb_we && (wb_rd == src);
    // younger producer first
    if (mem_hit)     sel = FWD_MEM;
    else if (wb_hit) sel = FWD_WB;
    else             sel = FWD_RF;
  end
endmodule

// File: rtl/hzd_load_use.sv
module hzd_load_use #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_we,
  input  logic          ex_is_load,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  output logic          hazard
);
  logic producer_ok;

  always_comb begin
    producer_ok = ex_is_load && ex_we && (ex_rd != '0);
    hazard      = producer_ok && ((ex_rd == id_rs1) || (ex_rd == id_rs2));
  end
endmodule

// File: rtl/hzd_arbiter.sv
module hzd_arbiter (
  input  logic run_ok,
  input  logic hazard,
  input  logic stalled_last,
  input  logic br_valid,
  input  logic br_mispredict,
  output logic stall,
  output logic redirect
);
  always_comb begin
    redirect = br_valid && br_mispredict;
    // a squash overrides a hold; a hold never repeats back to back
    stall    = run_ok && hazard && !stalled_last && !redirect;
  end
endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl
  import hzd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic [AW-1:0] ex_rs1,
  input  logic [AW-1:0] ex_rs2,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_we,
  input  logic          ex_is_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_we,
  input  logic          br_valid,
  input  logic          br_mispredict,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          stall_fd,
  output logic          bubble_ex,
  output logic          flush_if,
  output logic          flush_id
);
  localparam int NUM_SRC = 2;

  // reset release synchronizer
  logic rst_meta_q;
  logic rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  // operand forwarding, one selector per execute source
  logic [AW-1:0] ex_src [NUM_SRC];
  fwd_sel_e      sel    [NUM_SRC];

  always_comb begin
    ex_src[0] = ex_rs1;
    ex_src[1] = ex_rs2;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    hzd_fwd_mux #(.AW(AW)) u_mux (
      .src    (ex_src[g]),
      .mem_rd (mem_rd),
      .mem_we (mem_we),
      .wb_rd  (wb_rd),
      .wb_we  (wb_we),
      .sel    (sel[g])
    );
  end

  assign fwd_a = sel[0];
  assign fwd_b = sel[1];

  // load-use detection and stall/flush arbitration
  logic hazard;
  logic stall;
  logic redirect;
  logic stalled_q;
  logic stalled_d;
  logic stalled_en;

  hzd_load_use #(.AW(AW)) u_lu (
    .ex_rd      (ex_rd),
    .ex_we      (ex_we),
    .ex_is_load (ex_is_load),
    .id_rs1     (id_rs1),
    .id_rs2     (id_rs2),
    .hazard     (hazard)
  );

  hzd_arbiter u_arb (
    .run_ok        (rst_sync_q),
    .hazard        (hazard),
    .stalled_last  (stalled_q),
    .br_valid      (br_valid),
    .br_mispredict (br_mispredict),
    .stall         (stall),
    .redirect      (redirect)
  );

  always_comb begin
    stalled_en = rst_sync_q;
    stalled_d  = stall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          stalled_q <= 1'b0;
    else if (stalled_en) stalled_q <= stalled_d;
  end

  assign stall_fd  = stall;
  assign bubble_ex = stall;
  assign flush_if  = redirect;
  assign flush_id  = redirect;
endmodule

// File: rtl/hzd_checker.sv
module hzd_checker #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] ex_rs1,
  input logic [AW-1:0] ex_rs2,
  input logic          ex_we,
  input logic          ex_is_load,
  input logic [AW-1:0] mem_rd,
  input logic          mem_we,
  input logic          wb_we,
  input logic          br_valid,
  input logic          br_mispredict,
  input logic [1:0]    fwd_a,
  input logic [1:0]    fwd_b,
  input logic          stall_fd,
  input logic          bubble_ex,
  input logic          flush_if,
  input logic          flush_id
);
  // R3
  mem_first_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && (mem_rd == ex_rs1) && (ex_rs1 != '0)) |-> (fwd_a == 2'b10));
  // R3
  mem_first_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && (mem_rd == ex_rs2) && (ex_rs2 != '0)) |-> (fwd_b == 2'b10));
  // R4
  zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ex_rs1 == '0) |-> (fwd_a == 2'b00)) and ((ex_rs2 == '0) |-> (fwd_b == 2'b00)));
  // R5
  no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we && !wb_we) |-> ((fwd_a == 2'b00) && (fwd_b == 2'b00)));
  // R6
  stall_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_fd |-> (ex_is_load && ex_we && bubble_ex));
  // R7
  single_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_fd |=> !stall_fd);
  // R9
  twin_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_if || flush_id) |-> (flush_if && flush_id && br_valid && br_mispredict));
  // R10
  flush_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_if |-> (!stall_fd && !bubble_ex));
endmodule

bind pipe_hazard_ctl hzd_checker #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ex_rs1        (ex_rs1),
  .ex_rs2        (ex_rs2),
  .ex_we         (ex_we),
  .ex_is_load    (ex_is_load),
  .mem_rd        (mem_rd),
  .mem_we        (mem_we),
  .wb_we         (wb_we),
  .br_valid      (br_valid),
  .br_mispredict (br_mispredict),
  .fwd_a         (fwd_a),
  .fwd_b         (fwd_b),
  .stall_fd      (stall_fd),
  .bubble_ex     (bubble_ex),
  .flush_if      (flush_if),
  .flush_id      (flush_id)
);

// File: tb/sim_pipe_hazard_ctl.sv
module sim_pipe_hazard_ctl;
  localparam int AW = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic          ex_we, ex_is_load, mem_we, wb_we, br_valid, br_mispredict;
  logic [1:0]    fwd_a, fwd_b;
  logic          stall_fd, bubble_ex, flush_if, flush_id;

  int checks = 0;
  int fails  = 0;
  bit model_prev = 1'b0;
  bit model_next = 1'b0;

  pipe_hazard_ctl #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .id_rs1(id_rs1), .id_rs2(id_rs2),
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd),
    .ex_we(ex_we), .ex_is_load(ex_is_load),
    .mem_rd(mem_rd), .mem_we(mem_we),
    .wb_rd(wb_rd), .wb_we(wb_we),
    .br_valid(br_valid), .br_mispredict(br_mispredict),
    .fwd_a(fwd_a), .fwd_b(fwd_b),
    .stall_fd(stall_fd), .bubble_ex(bubble_ex),
    .flush_if(flush_if), .flush_id(flush_id)
  );

  function automatic logic [1:0] ref_sel(logic [AW-1:0] s);
    if (s == 0) return 2'b00;
    if (mem_we && mem_rd == s) return 2'b10;
    if (wb_we && wb_rd == s) return 2'b01;
    return 2'b00;
  endfunction

  task automatic drive(input int i1, input int i2, input int e1, input int e2,
                       input int erd, input bit ewe, input bit eld,
                       input int mrd, input bit mwe, input int wrd, input bit wwe,
                       input bit bv, input bit bm);
    id_rs1 = AW'(i1); id_rs2 = AW'(i2);
    ex_rs1 = AW'(e1); ex_rs2 = AW'(e2); ex_rd = AW'(erd);
    ex_we = ewe; ex_is_load = eld;
    mem_rd = AW'(mrd); mem_we = mwe; wb_rd = AW'(wrd); wb_we = wwe;
    br_valid = bv; br_mispredict = bm;
  endtask

  // compare all outputs against the behavioural model, then advance one clock
  task automatic step(input string tag);
    bit hz, mis, st;
    logic [7:0] got, exp;
    #2;
    mis = br_valid && br_mispredict;
    hz  = ex_is_load && ex_we && (ex_rd != 0) && (ex_rd == id_rs1 || ex_rd == id_rs2);
    st  = hz && !model_prev && !mis;
    exp = {ref_sel(ex_rs1), ref_sel(ex_rs2), st, st, mis, mis};
    got = {fwd_a, fwd_b, stall_fd, bubble_ex, flush_if, flush_id};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: {fwd_a,fwd_b,stall,bubble,flush_if,flush_id} actual=%b expected=%b",
               tag, got, exp);
    end
    model_next = st;
    @(posedge clk);
    model_prev = model_next;
    @(negedge clk);
  endtask

  task automatic reset_check(input string tag);
    #2;
    checks++;
    if (stall_fd !== 1'b0) begin
      fails++;
      $display("FAIL %s: stall_fd actual=%b expected=0", tag, stall_fd);
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    // load-use pattern present during reset
    drive(9, 0, 0, 0, 9, 1, 1, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    reset_check("R12 reset asserted");
    rst_n = 1'b1;
    reset_check("R12 release cycle");
    @(posedge clk);
    @(negedge clk);
    reset_check("R12 first edge after release");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    model_prev = 1'b0;
    step("R11 idle");

    // R1 memory stage forward on source a
    drive(0, 0, 3, 8, 0, 0, 0, 3, 1, 0, 0, 0, 0);
    step("R1");
    // R2 writeback forward on source b
    drive(0, 0, 1, 4, 0, 0, 0, 6, 1, 4, 1, 0, 0);
    step("R2");
    // R3 both stages match both sources
    drive(0, 0, 5, 5, 0, 0, 0, 5, 1, 5, 1, 0, 0);
    step("R3");
    // R4 index zero everywhere, including a load to zero
    drive(0, 0, 0, 0, 0, 1, 1, 0, 1, 0, 1, 0, 0);
    step("R4");
    // R5 memory stage disabled, writeback takes over; then both disabled
    drive(0, 0, 3, 3, 0, 0, 0, 3, 0, 3, 1, 0, 0);
    step("R5 mem disabled");
    drive(0, 0, 3, 3, 0, 0, 0, 3, 0, 3, 0, 0, 0);
    step("R5 both disabled");
    // R11 no match at all
    drive(0, 0, 7, 12, 0, 0, 0, 6, 1, 2, 1, 0, 0);
    step("R11");

    // R6 load-use on decode source 2, then R7 hazard held
    drive(1, 9, 0, 0, 9, 1, 1, 0, 0, 0, 0, 0, 0);
    step("R6 stall");
    step("R7 held hazard no repeat");
    step("R7 stall may recur");
    // bubble in execute, load in memory
    drive(1, 9, 0, 0, 0, 0, 0, 9, 1, 0, 0, 0, 0);
    step("R6 bubble cycle");
    // dependent in execute, load now in writeback
    drive(0, 0, 1, 9, 0, 0, 0, 0, 0, 9, 1, 0, 0);
    step("R6 forward loaded value");

    // R8 non-load producer: no stall, then memory forward
    drive(9, 2, 0, 0, 9, 1, 0, 0, 0, 0, 0, 0, 0);
    step("R8 no stall");
    drive(0, 0, 9, 2, 0, 0, 0, 9, 1, 0, 0, 0, 0);
    step("R8 forward");

    // R9 mispredict, correct prediction, no branch
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    step("R9 mispredict");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    step("R9 predicted");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    step("R9 not valid");

    // R10 flush beats stall, then hazard stalls next cycle
    drive(4, 0, 0, 0, 4, 1, 1, 0, 0, 0, 0, 1, 1);
    step("R10 flush wins");
    drive(4, 0, 0, 0, 4, 1, 1, 0, 0, 0, 0, 0, 0);
    step("R10 stall after flush");

    // dense collisions across all requirements
    for (int n = 0; n < 400; n++) begin
      drive($urandom_range(3, 0), $urandom_range(3, 0), $urandom_range(3, 0),
            $urandom_range(3, 0), $urandom_range(3, 0), 1'($urandom_range(1, 0)),
            1'($urandom_range(1, 0)), $urandom_range(3, 0), 1'($urandom_range(1, 0)),
            $urandom_range(3, 0), 1'($urandom_range(1, 0)),
            1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)));
      step("mixed R1 R3 R6 R7 R9 R10");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule